// File: doc/BRIEF.md
# Prioritizing Interrupt Distributor

This block collects peripheral interrupt lines for a small multi-core system. For each line it keeps a pending and an active state. A word-addressed 32-bit register bus holds the per-interrupt settings: enable, an 8-bit priority, a mask of target cores and the trigger mode. For every core the block registers one offer: the ID and priority of the best interrupt that is enabled, pending, not active and aimed at that core.

A core takes the offer with a one-cycle acknowledge pulse, which makes the interrupt active. Later the core returns the ID with an end-of-interrupt pulse, which clears the active state. Software can also clear the active state through the bus. IDs below 32 are private and always level-sensitive. IDs from 32 upward may be set to edge mode. The default build has 64 interrupts, 2 cores and an 8-bit word address. NUM_IRQ must be a multiple of 32, and NUM_CORES must be at most 8.

Bus access works as follows. A write lands on the clock edge where `bus_req` and `bus_we` are high. A read (`bus_req` high, `bus_we` low) returns its data on `bus_rdata` after that edge and holds it until the next read. A word that is not mapped reads 0.

Top module: `irq_distributor`

## Requirements
- R1: After reset the control bit, every enable, priority, target and trigger field is 0, and no core is offered an interrupt.
- R2: Word 1 is read-only. Bits [4:0] hold NUM_IRQ/32-1 and bits [7:5] hold NUM_CORES-1, so the default build reads 0x21.
- R3: Bit 0 of word 0 is the global forward enable. While it is 0, no core sees `cpu_irq_valid` high.
- R4: Set-enable words 8..9 and clear-enable words 10..11 cover 32 IDs per word, with ID 32w+b at bit b. Writing a 1 bit sets or clears that enable, and writing 0 has no effect. Both banks read back the enable state.
- R5: Priority words 16..31 hold ID 4w+b in byte b of word w. A lower value wins, and among equal values the lowest ID wins.
- R6: Target words 32..47 use the same byte layout. Bit k of a byte selects core k. Bits at and above NUM_CORES are dropped and read 0. An interrupt is offered only to the cores in its mask.
- R7: Trigger words 48..51 hold ID 16w+j in bits [2j+1:2j]. The upper bit set to 1 selects edge mode, and the lower bit reads 0. Writes to fields of IDs below 32 are ignored, and those fields read 0.
- R8: A level interrupt is pending while its line is high and it is not active. Words 14..15 read the pending state with the 32-per-word layout.
- R9: An edge interrupt becomes pending on a rising edge of its line and stays pending after the line falls, until an acknowledge takes it. A rising edge that lands in the acknowledge cycle leaves it pending.
- R10: An acknowledge pulse while the core's offer is valid makes the offered ID active, and the offer drops in the next cycle. An active interrupt is not offered. An acknowledge with no valid offer changes nothing.
- R11: An end-of-interrupt pulse clears the active state of `cpu_eoi_id`. Writing 1 bits to words 12..13 clears the active state of those IDs. These words read the active state.
- R12: The offer is registered. It appears a few cycles after its inputs settle and carries the ID and priority of the winning interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| bus_req | input | 1 | bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | word address |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | registered read data |
| irq_in | input | NUM_IRQ | interrupt lines, bit i = ID i |
| cpu_irq_valid | output | NUM_CORES | offer valid per core |
| cpu_irq_id | output | NUM_CORES*ID_W | offered ID, core c at [c*ID_W +: ID_W] |
| cpu_irq_prio | output | NUM_CORES*8 | offered priority, core c at [c*8 +: 8] |
| cpu_ack | input | NUM_CORES | acknowledge pulse per core |
| cpu_eoi | input | NUM_CORES | end-of-interrupt pulse per core |
| cpu_eoi_id | input | NUM_CORES*ID_W | ID returned with the end-of-interrupt pulse |

## Verification
The bench forces two events into the same cycle: a new rising edge on an edge-mode line, and the acknowledge that retires its earlier pending state. To do this it raises the line one cycle ahead of the acknowledge pulse, so that the line's synchronizer reports the edge exactly on the acknowledge edge. The result is judged through the bus. The pending and active words must then both show the ID, and after an end-of-interrupt the same ID must be offered again. A vector table separately walks the priority and lowest-ID tie-break order.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  typedef logic [7:0] prio_t;
  localparam int unsigned CTL_WORD  = 0;
  localparam int unsigned TYPE_WORD = 1;
  localparam int unsigned BANK_BASE = 8;

  function automatic int unsigned words_of(input int unsigned n, input int unsigned per);
    return (n + per - 1) / per;
  endfunction
endpackage

// File: rtl/irqd_regfile.sv
module irqd_regfile
  import irqd_pkg::*;
#(
  parameter int NUM_IRQ   = 64,
  parameter int NUM_CORES = 2,
  parameter int ADDR_W    = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           bus_req,
  input  logic                           bus_we,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [31:0]                    bus_wdata,
  output logic [31:0]                    bus_rdata,
  input  logic [NUM_IRQ-1:0]             pend,
  input  logic [NUM_IRQ-1:0]             act,
  output logic                           ctl_en,
  output logic [NUM_IRQ-1:0]             en_q,
  output logic [NUM_IRQ*8-1:0]           prio_flat,
  output logic [NUM_IRQ*NUM_CORES-1:0]   tgt_flat,
  output logic [NUM_IRQ-1:0]             edge_cfg,
  output logic [NUM_IRQ-1:0]             clr_act
);
  localparam int unsigned W32     = words_of(NUM_IRQ, 32);
  localparam int unsigned W4      = words_of(NUM_IRQ, 4);
  localparam int unsigned W16     = words_of(NUM_IRQ, 16);
  localparam int unsigned SETEN_B = BANK_BASE;
  localparam int unsigned CLREN_B = SETEN_B + W32;
  localparam int unsigned CLRAC_B = CLREN_B + W32;
  localparam int unsigned PEND_B  = CLRAC_B + W32;
  localparam int unsigned PRIO_B  = PEND_B + W32;
  localparam int unsigned TGT_B   = PRIO_B + W4;
  localparam int unsigned CFG_B   = TGT_B + W4;
  localparam logic [31:0] TYPE_VAL = 32'(((NUM_CORES - 1) << 5) | (W32 - 1));

  logic        wr;
  prio_t       prio_q [NUM_IRQ];
  logic [NUM_CORES-1:0] tgt_q [NUM_IRQ];
  logic [31:0] rd_nxt;

  assign wr = bus_req && bus_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_en   <= 1'b0;
      en_q     <= '0;
      edge_cfg <= '0;
      for (int i = 0; i < NUM_IRQ; i++) begin
        prio_q[i] <= '0;
        tgt_q[i]  <= '0;
      end
    end else if (wr) begin
      if (bus_addr == ADDR_W'(CTL_WORD)) ctl_en <= bus_wdata[0];
      for (int w = 0; w < int'(W32); w++) begin
        if (bus_addr == ADDR_W'(SETEN_B + w)) en_q[w*32 +: 32] <= en_q[w*32 +: 32] | bus_wdata;
        if (bus_addr == ADDR_W'(CLREN_B + w)) en_q[w*32 +: 32] <= en_q[w*32 +: 32] & ~bus_wdata;
      end
      for (int w = 0; w < int'(W4); w++) begin
        if (bus_addr == ADDR_W'(PRIO_B + w))
          for (int b = 0; b < 4; b++) prio_q[4*w+b] <= bus_wdata[8*b +: 8];
        if (bus_addr == ADDR_W'(TGT_B + w))
          for (int b = 0; b < 4; b++) tgt_q[4*w+b] <= bus_wdata[8*b +: NUM_CORES];
      end
      for (int w = 0; w < int'(W16); w++) begin
        if (bus_addr == ADDR_W'(CFG_B + w))
          for (int j = 0; j < 16; j++)
            if (16*w + j >= 32) edge_cfg[16*w+j] <= bus_wdata[2*j+1];
      end
    end
  end

  // one-cycle clear-active strobes, applied by the state tracker
  always_comb begin
    clr_act = '0;
    for (int w = 0; w < int'(W32); w++)
      if (wr && bus_addr == ADDR_W'(CLRAC_B + w)) clr_act[w*32 +: 32] = bus_wdata;
  end

  always_comb begin
    rd_nxt = '0;
    if (bus_addr == ADDR_W'(CTL_WORD))  rd_nxt[0] = ctl_en;
    if (bus_addr == ADDR_W'(TYPE_WORD)) rd_nxt = TYPE_VAL;
    for (int w = 0; w < int'(W32); w++) begin
      if (bus_addr == ADDR_W'(SETEN_B + w) || bus_addr == ADDR_W'(CLREN_B + w))
        rd_nxt = en_q[w*32 +: 32];
      if (bus_addr == ADDR_W'(CLRAC_B + w)) rd_nxt = act[w*32 +: 32];
      if (bus_addr == ADDR_W'(PEND_B + w))  rd_nxt = pend[w*32 +: 32];
    end
    for (int w = 0; w < int'(W4); w++) begin
      if (bus_addr == ADDR_W'(PRIO_B + w))
        for (int b = 0; b < 4; b++) rd_nxt[8*b +: 8] = prio_q[4*w+b];
      if (bus_addr == ADDR_W'(TGT_B + w))
        for (int b = 0; b < 4; b++) rd_nxt[8*b +: NUM_CORES] = tgt_q[4*w+b];
    end
    for (int w = 0; w < int'(W16); w++)
      if (bus_addr == ADDR_W'(CFG_B + w))
        for (int j = 0; j < 16; j++) rd_nxt[2*j+1] = edge_cfg[16*w+j];
  end

  always_ff @(posedge clk) begin
    if (rst)                    bus_rdata <= '0;
    else if (bus_req && !bus_we) bus_rdata <= rd_nxt;
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_flat
    assign prio_flat[i*8 +: 8]               = prio_q[i];
    assign tgt_flat[i*NUM_CORES +: NUM_CORES] = tgt_q[i];
  end

  for (genvar w = 0; w < int'(W32); w++) begin : g_en_chk
    // R4: a set-enable write leaves every written 1 bit enabled
    p_set_en_r4: assert property (@(posedge clk) disable iff (rst)
      (bus_req && bus_we && bus_addr == ADDR_W'(SETEN_B + w))
      |=> ((en_q[w*32 +: 32] & $past(bus_wdata)) == $past(bus_wdata)));
    // R4: a clear-enable write leaves every written 1 bit disabled
    p_clr_en_r4: assert property (@(posedge clk) disable iff (rst)
      (bus_req && bus_we && bus_addr == ADDR_W'(CLREN_B + w))
      |=> ((en_q[w*32 +: 32] & $past(bus_wdata)) == '0));
  end
endmodule

// File: rtl/irqd_state.sv
module irqd_state #(
  parameter int NUM_IRQ = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic [NUM_IRQ-1:0] edge_cfg,
  input  logic [NUM_IRQ-1:0] ack_hit,
  input  logic [NUM_IRQ-1:0] eoi_hit,
  input  logic [NUM_IRQ-1:0] clr_act,
  output logic [NUM_IRQ-1:0] pend,
  output logic [NUM_IRQ-1:0] act
);
  logic [NUM_IRQ-1:0] line_q, line_q2, epend_q, act_q, rise;

  assign rise = line_q & ~line_q2;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q  <= '0;
      line_q2 <= '0;
      epend_q <= '0;
      act_q   <= '0;
    end else begin
      line_q  <= irq_in;
      line_q2 <= line_q;
      // a fresh edge outranks the acknowledge that retires the old one
      epend_q <= edge_cfg & ((epend_q & ~ack_hit) | rise);
      act_q   <= (act_q & ~(eoi_hit | clr_act)) | ack_hit;
    end
  end

  assign pend = (edge_cfg & epend_q) | (~edge_cfg & line_q & ~act_q);
  assign act  = act_q;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_chk
    // R10: only an acknowledge can make an interrupt active
    p_act_by_ack_r10: assert property (@(posedge clk) disable iff (rst)
      (!act_q[i] && !ack_hit[i]) |=> act_q[i] == 1'b0);
    // R9: edge pending state survives until an acknowledge takes it
    p_edge_hold_r9: assert property (@(posedge clk) disable iff (rst)
      (edge_cfg[i] && epend_q[i] && !ack_hit[i]) |=> epend_q[i]);
  end
endmodule

// File: rtl/irqd_select.sv
module irqd_select
  import irqd_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int ID_W    = $clog2(NUM_IRQ)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_IRQ-1:0]   elig,
  input  logic [NUM_IRQ*8-1:0] prio_flat,
  input  logic                 ack,
  output logic                 valid_q,
  output logic [ID_W-1:0]      id_q,
  output prio_t                prio_q
);
  logic      found;
  logic [ID_W-1:0] best_id;
  prio_t     best_p;

  // ascending scan with strict compare keeps the lowest ID on a tie
  always_comb begin
    found   = 1'b0;
    best_id = '0;
    best_p  = '1;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (elig[i] && (!found || prio_flat[i*8 +: 8] < best_p)) begin
        found   = 1'b1;
        best_id = ID_W'(i);
        best_p  = prio_flat[i*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      id_q    <= '0;
      prio_q  <= '0;
    end else begin
      valid_q <= found && !ack;
      id_q    <= best_id;
      prio_q  <= best_p;
    end
  end

  // R10: an acknowledged offer is withdrawn in the following cycle
  p_ack_drop_r10: assert property (@(posedge clk) disable iff (rst)
    ack |=> !valid_q);
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
  import irqd_pkg::*;
#(
  parameter int NUM_IRQ   = 64,
  parameter int NUM_CORES = 2,
  parameter int ADDR_W    = 8,
  localparam int ID_W     = $clog2(NUM_IRQ)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        bus_req,
  input  logic                        bus_we,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [31:0]                 bus_wdata,
  output logic [31:0]                 bus_rdata,
  input  logic [NUM_IRQ-1:0]          irq_in,
  output logic [NUM_CORES-1:0]        cpu_irq_valid,
  output logic [NUM_CORES*ID_W-1:0]   cpu_irq_id,
  output logic [NUM_CORES*8-1:0]      cpu_irq_prio,
  input  logic [NUM_CORES-1:0]        cpu_ack,
  input  logic [NUM_CORES-1:0]        cpu_eoi,
  input  logic [NUM_CORES*ID_W-1:0]   cpu_eoi_id
);
  logic                          ctl_en;
  logic [NUM_IRQ-1:0]            en_q, edge_cfg, clr_act, pend, act, ack_hit, eoi_hit;
  logic [NUM_IRQ*8-1:0]          prio_flat;
  logic [NUM_IRQ*NUM_CORES-1:0]  tgt_flat;
  logic [ID_W-1:0]               off_id [NUM_CORES];

  irqd_regfile #(.NUM_IRQ(NUM_IRQ), .NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_regs (
    .clk, .rst, .bus_req, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
    .pend, .act, .ctl_en, .en_q, .prio_flat, .tgt_flat, .edge_cfg, .clr_act
  );

  irqd_state #(.NUM_IRQ(NUM_IRQ)) u_state (
    .clk, .rst, .irq_in, .edge_cfg, .ack_hit, .eoi_hit, .clr_act, .pend, .act
  );

  always_comb begin
    ack_hit = '0;
    eoi_hit = '0;
    for (int i = 0; i < NUM_IRQ; i++)
      for (int c = 0; c < NUM_CORES; c++) begin
        if (cpu_ack[c] && cpu_irq_valid[c] && off_id[c] == ID_W'(i)) ack_hit[i] = 1'b1;
        if (cpu_eoi[c] && cpu_eoi_id[c*ID_W +: ID_W] == ID_W'(i))  eoi_hit[i] = 1'b1;
      end
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic [NUM_IRQ-1:0] elig;
    always_comb
      for (int i = 0; i < NUM_IRQ; i++)
        elig[i] = ctl_en && pend[i] && !act[i] && en_q[i] && tgt_flat[i*NUM_CORES + c];

    irqd_select #(.NUM_IRQ(NUM_IRQ), .ID_W(ID_W)) u_sel (
      .clk, .rst, .elig, .prio_flat, .ack(cpu_ack[c]),
      .valid_q(cpu_irq_valid[c]), .id_q(off_id[c]), .prio_q(cpu_irq_prio[c*8 +: 8])
    );
    assign cpu_irq_id[c*ID_W +: ID_W] = off_id[c];
  end

  // R3: with forwarding off, no core is offered anything one cycle later
  p_ctl_gate_r3: assert property (@(posedge clk) disable iff (rst)
    !ctl_en |=> (cpu_irq_valid == '0));
endmodule

// File: tb/sim_irq_distributor.sv
`timescale 1ns/1ps
module sim_irq_distributor;
  localparam logic [7:0] A_CTL = 0, A_TYPE = 1, A_SETEN = 8, A_CLREN = 10, A_CLRACT = 12,
                         A_PEND = 14, A_PRIO = 16, A_TGT = 32, A_CFG = 48;
  // {idA, prioA, idB, prioB, expected winner}
  localparam logic [33:0] VEC [6] = '{
    {6'd3,  8'h40, 6'd40, 8'h20, 6'd40},
    {6'd3,  8'h20, 6'd40, 8'h40, 6'd3},
    {6'd10, 8'h80, 6'd5,  8'h80, 6'd5},
    {6'd63, 8'h00, 6'd0,  8'h01, 6'd63},
    {6'd33, 8'h7F, 6'd62, 8'h7F, 6'd33},
    {6'd20, 8'hFF, 6'd21, 8'hFE, 6'd21}
  };

  logic clk = 0, rst = 1;
  logic bus_req = 0, bus_we = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [63:0] irq = 0;
  logic [1:0] cpu_irq_valid, cpu_ack = 0, cpu_eoi = 0;
  logic [11:0] cpu_irq_id, cpu_eoi_id = 0;
  logic [15:0] cpu_irq_prio;
  int checks = 0, errors = 0;
  logic [7:0] prio_m [64];
  logic [7:0] tgt_m [64];
  logic [31:0] d;

  always #10 clk = ~clk;

  irq_distributor u0 (
    .clk, .rst, .bus_req, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
    .irq_in(irq), .cpu_irq_valid, .cpu_irq_id, .cpu_irq_prio,
    .cpu_ack, .cpu_eoi, .cpu_eoi_id
  );

  task automatic chk(input string tag, input logic [31:0] a, input logic [31:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] v);
    @(negedge clk); bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = v;
    @(negedge clk); bus_req = 0; bus_we = 0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk); bus_req = 1; bus_we = 0; bus_addr = a;
    @(negedge clk); bus_req = 0; v = bus_rdata;
  endtask

  task automatic set_prio(input int id, input logic [7:0] p);
    int w;
    prio_m[id] = p; w = id / 4;
    bus_write(8'(A_PRIO + w), {prio_m[4*w+3], prio_m[4*w+2], prio_m[4*w+1], prio_m[4*w]});
  endtask

  task automatic set_tgt(input int id, input logic [7:0] m);
    int w;
    tgt_m[id] = m; w = id / 4;
    bus_write(8'(A_TGT + w), {tgt_m[4*w+3], tgt_m[4*w+2], tgt_m[4*w+1], tgt_m[4*w]});
  endtask

  task automatic enable(input int id);
    bus_write(8'(A_SETEN + id / 32), 32'(1) << (id % 32));
  endtask

  task automatic settle; repeat (4) @(negedge clk); endtask

  task automatic ack(input int c);
    @(negedge clk); cpu_ack[c] = 1;
    @(negedge clk); cpu_ack[c] = 0;
  endtask

  task automatic eoi(input int c, input int id);
    @(negedge clk); cpu_eoi[c] = 1; cpu_eoi_id[c*6 +: 6] = 6'(id);
    @(negedge clk); cpu_eoi[c] = 0;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    for (int i = 0; i < 64; i++) begin prio_m[i] = 0; tgt_m[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    chk("R1 no offer", {30'd0, cpu_irq_valid}, 0);
    bus_read(A_CTL, d);   chk("R1 control", d, 0);
    bus_read(A_SETEN, d); chk("R1 enable", d, 0);
    bus_read(A_PRIO, d);  chk("R1 priority", d, 0);
    bus_read(A_TGT, d);   chk("R1 target", d, 0);
    bus_read(8'(A_CFG + 2), d); chk("R1 trigger", d, 0);
    // R2: capacity word
    bus_read(A_TYPE, d);  chk("R2 type word", d, 32'h21);

    bus_write(A_CTL, 1);
    // R5 R12: priority and tie-break table
    for (int k = 0; k < 6; k++) begin
      int a, b;
      logic [7:0] pa, pb;
      logic [5:0] ex;
      a = int'(VEC[k][33:28]); pa = VEC[k][27:20];
      b = int'(VEC[k][19:14]); pb = VEC[k][13:6]; ex = VEC[k][5:0];
      bus_write(A_CLREN, '1); bus_write(8'(A_CLREN + 1), '1);
      set_prio(a, pa); set_prio(b, pb); set_tgt(a, 1); set_tgt(b, 1);
      enable(a); enable(b);
      irq = 0; irq[a] = 1; irq[b] = 1;
      settle();
      chk("R5 R12 winner id", {25'd0, cpu_irq_valid[0], cpu_irq_id[5:0]}, {25'd0, 1'b1, ex});
      chk("R5 R12 winner prio", {24'd0, cpu_irq_prio[7:0]}, {24'd0, (ex == 6'(a)) ? pa : pb});
      irq = 0;
      settle();
    end

    // R3: global gate
    bus_write(A_CLREN, '1); bus_write(8'(A_CLREN + 1), '1);
    set_prio(7, 8'h10); set_tgt(7, 1); enable(7);
    irq[7] = 1; settle();
    chk("R3 offered when on", {26'd0, cpu_irq_valid, cpu_irq_id[5:0]}, {26'd0, 2'b01, 6'd7});
    bus_write(A_CTL, 0); settle();
    chk("R3 gated when off", {30'd0, cpu_irq_valid}, 0);
    bus_write(A_CTL, 1); settle();

    // R6: targeting
    set_tgt(7, 2); settle();
    chk("R6 core1 only", {26'd0, cpu_irq_valid, cpu_irq_id[11:6]}, {26'd0, 2'b10, 6'd7});
    bus_write(8'(A_TGT + 1), 32'hFF00_0000); bus_read(8'(A_TGT + 1), d);
    chk("R6 unused target bits", d, 32'h0300_0000);
    settle();
    chk("R6 both cores", {30'd0, cpu_irq_valid}, 2'b11);
    set_tgt(7, 1); settle();

    // R8 R10 R11: level interrupt life cycle on core 0
    ack(0);
    chk("R10 offer drops after ack", {30'd0, cpu_irq_valid}, 0);
    bus_read(A_PEND, d);   chk("R8 level masked while active", d & 32'h80, 0);
    bus_read(A_CLRACT, d); chk("R10 active set", d, 32'h80);
    eoi(0, 7);
    bus_read(A_CLRACT, d); chk("R11 eoi clears active", d, 0);
    bus_read(A_PEND, d);   chk("R8 level pending again", d, 32'h80);
    settle();
    chk("R8 reoffered", {25'd0, cpu_irq_valid[0], cpu_irq_id[5:0]}, {25'd0, 1'b1, 6'd7});
    ack(0);
    bus_write(A_CLRACT, 32'h80);
    bus_read(A_CLRACT, d); chk("R11 bus clear-active", d, 0);
    irq[7] = 0; settle();
    bus_read(A_PEND, d);   chk("R8 line low not pending", d, 0);
    ack(0);
    bus_read(A_CLRACT, d); chk("R10 ack without offer ignored", d, 0);

    // R7: trigger fields
    bus_write(A_CFG, '1); bus_read(A_CFG, d);
    chk("R7 private trigger ignored", d, 0);
    bus_write(8'(A_CFG + 2), '1); bus_read(8'(A_CFG + 2), d);
    chk("R7 shared trigger upper bits", d, 32'hAAAA_AAAA);
    bus_write(8'(A_CFG + 2), 32'h0002_0000);

    // R9: edge interrupt on ID 40
    set_prio(40, 8'h30); set_tgt(40, 1); enable(40);
    @(negedge clk); irq[40] = 1; @(negedge clk); irq[40] = 0;
    settle();
    bus_read(8'(A_PEND + 1), d); chk("R9 edge latched", d, 32'h100);
    chk("R9 edge offered", {25'd0, cpu_irq_valid[0], cpu_irq_id[5:0]}, {25'd0, 1'b1, 6'd40});
    ack(0);
    bus_read(8'(A_PEND + 1), d);   chk("R9 ack clears edge pending", d, 0);
    bus_read(8'(A_CLRACT + 1), d); chk("R10 edge active", d, 32'h100);
    eoi(0, 40); settle();
    chk("R9 no reoffer", {30'd0, cpu_irq_valid}, 0);

    // R9: new edge in the acknowledge cycle
    @(negedge clk); irq[40] = 1; @(negedge clk); irq[40] = 0;
    settle();
    @(negedge clk); irq[40] = 1;
    @(negedge clk); cpu_ack[0] = 1;
    @(negedge clk); cpu_ack[0] = 0; irq[40] = 0;
    bus_read(8'(A_PEND + 1), d);   chk("R9 edge in ack cycle kept", d, 32'h100);
    bus_read(8'(A_CLRACT + 1), d); chk("R10 active with new edge", d, 32'h100);
    eoi(0, 40); settle();
    chk("R9 R11 reoffered after eoi", {25'd0, cpu_irq_valid[0], cpu_irq_id[5:0]}, {25'd0, 1'b1, 6'd40});
    ack(0); eoi(0, 40);

    // R4: zero writes have no effect
    bus_write(8'(A_CLREN + 1), 0); bus_write(8'(A_SETEN + 1), 0);
    bus_read(8'(A_SETEN + 1), d); chk("R4 zero write no effect", d, 32'h100);
    bus_write(8'(A_CLREN + 1), 32'h100);
    bus_read(8'(A_CLREN + 1), d); chk("R4 clear-enable", d, 0);

    summary();
  end
endmodule